// File: doc/BRIEF.md
# Masked-Write General-Purpose Pin Port

A 32-pin general-purpose I/O port controlled through a small memory-mapped register bank of 32-bit words. Each pin has a direction bit (1 means the pin drives its pad) and an output value bit. Direction bits change only through a pair of registers: one turns the selected pins into outputs, the other turns them into inputs. Bits written as zero leave their pins alone, so software never needs a read-modify-write. The output values are split across two half-word registers. In each of them, the upper 16 bits of the write data are a per-pin enable and the lower 16 bits are the new values, so any subset of pins can be changed in one write.

The pad inputs pass through a two-flop synchroniser before they reach a readable input register. The value register always drives `pad_out`, whatever the direction, so a level loaded before the pin is switched to output reaches the pad at once. Register access uses a request channel that is always ready and a registered response that returns read data one cycle after the read is accepted.

Top module: `pin_port`

## Requirements
- R1: After reset, `pad_oe` and `pad_out` are all zero and `rsp_valid` is low.
- R2: A write to offset 0x00 sets the direction bit of every pin whose write-data bit is 1. Pins whose bit is 0 keep their direction. The new `pad_oe` is visible after the accepting clock edge.
- R3: A write to offset 0x04 clears the direction bit of every pin whose write-data bit is 1. Pins whose bit is 0 keep their direction.
- R4: A write to offset 0x08 updates pins 0–15. For each i in 0–15, if write-data bit i+16 is 1 then `pad_out[i]` takes write-data bit i; otherwise `pad_out[i]` is unchanged.
- R5: A write to offset 0x0C updates pins 16–31. For each i in 0–15, if write-data bit i+16 is 1 then `pad_out[16+i]` takes write-data bit i; otherwise `pad_out[16+i]` is unchanged.
- R6: `pad_out` shows the stored output values whether or not the pin is an output. A value loaded while a pin is an input is on `pad_out` in the same cycle that `pad_oe` for that pin rises.
- R7: A read of offset 0x04 returns the direction mask, with bit n = 1 meaning pin n is an output.
- R8: A read of offset 0x10 returns `pad_in` after two synchroniser flops. A level applied before accepting edge k is returned by reads accepted at edge k+2 or later. Reads accepted at edges k and k+1 still return the previous level.
- R9: `rsp_valid` is high for exactly the one cycle after each accepted read and never follows a write. Reads of offsets 0x00, 0x08 and 0x0C and of any unmapped offset return 0.
- R10: Writes to offset 0x10 or to any unmapped offset leave `pad_oe` and `pad_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The bench checks that the set and clear registers touch only the bits written as one. A design that wrote the whole mask instead would switch unrelated pins to input or output. It checks that a half-word write with a partial enable field leaves the disabled pins alone, and that enables in the high-pin register land on pins 16–31. Mistakes there would show as pins that keep losing their value, or as low pins that move on a high write. It checks that a value preloaded while the pin is an input reaches `pad_out` at once, which catches a design that gates the value with the enable. It also counts the exact read latency through the synchroniser and confirms that writes to read-only or unmapped offsets corrupt no state.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
   localparam int unsigned REG_W = 32;

   localparam logic [31:0] OFS_DIR_SET = 32'h00;
   localparam logic [31:0] OFS_DIR_CLR = 32'h04;
   localparam logic [31:0] OFS_OUT_LO  = 32'h08;
   localparam logic [31:0] OFS_OUT_HI  = 32'h0C;
   localparam logic [31:0] OFS_PIN_IN  = 32'h10;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DIR_SET,
      SEL_DIR_CLR,
      SEL_OUT_LO,
      SEL_OUT_HI,
      SEL_PIN_IN
   } reg_sel_e;

   function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_DIR_SET: s = SEL_DIR_SET;
         OFS_DIR_CLR: s = SEL_DIR_CLR;
         OFS_OUT_LO:  s = SEL_OUT_LO;
         OFS_OUT_HI:  s = SEL_OUT_HI;
         OFS_PIN_IN:  s = SEL_PIN_IN;
         default:     s = SEL_NONE;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else begin
            if (s == 0) chain[s] <= d;
            else        chain[s] <= chain[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_dir_reg.sv
module pin_dir_reg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (set_en) begin
         dir_q <= dir_q | mask;
      end else if (clr_en) begin
         dir_q <= dir_q & ~mask;
      end
   end

   assign q = dir_q;
endmodule

// File: rtl/pin_out_half.sv
module pin_out_half #(
   parameter int unsigned HALF_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2*HALF_W-1:0] wdata,
   output logic [HALF_W-1:0]   q
);
   logic [HALF_W-1:0] val_q;
   logic [HALF_W-1:0] enable;
   logic [HALF_W-1:0] value;

   assign enable = wdata[2*HALF_W-1:HALF_W];
   assign value  = wdata[HALF_W-1:0];

   for (genvar i = 0; i < HALF_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                 val_q[i] <= 1'b0;
         else if (wr_en && enable[i]) val_q[i] <= value[i];
      end
   end

   assign q = val_q;
endmodule

// File: rtl/pin_port.sv
module pin_port
   import pin_port_pkg::*;
#(
   parameter int unsigned PIN_COUNT   = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [REG_W-1:0]     req_wdata,
   output logic                 rsp_valid,
   output logic [REG_W-1:0]     rsp_rdata,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic [PIN_COUNT-1:0] pad_oe
);
   localparam int unsigned HALF_W   = PIN_COUNT / 2;
   localparam int unsigned N_HALVES = PIN_COUNT / HALF_W;

   if (PIN_COUNT != REG_W) begin : g_bad_pins
      $error("pin_port: PIN_COUNT must equal the register width");
   end
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("pin_port: ADDR_W must be within 5..32");
   end

   reg_sel_e sel;
   logic     wr_fire;
   logic     rd_fire;

   assign req_ready = 1'b1;
   assign sel       = decode_offset(32'(req_addr));
   assign wr_fire   = req_valid && req_write;
   assign rd_fire   = req_valid && !req_write;

   // direction state
   logic [PIN_COUNT-1:0] dir_q;

   pin_dir_reg #(.WIDTH(PIN_COUNT)) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_fire && sel == SEL_DIR_SET),
      .clr_en (wr_fire && sel == SEL_DIR_CLR),
      .mask   (req_wdata),
      .q      (dir_q)
   );

   // output values, one masked half-word register per half
   logic [PIN_COUNT-1:0] out_q;

   for (genvar h = 0; h < N_HALVES; h++) begin : g_half
      logic half_wr;
      assign half_wr = wr_fire && (sel == ((h == 0) ? SEL_OUT_LO : SEL_OUT_HI));

      pin_out_half #(.HALF_W(HALF_W)) u_half (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (half_wr),
         .wdata (req_wdata),
         .q     (out_q[h*HALF_W +: HALF_W])
      );
   end

   // input synchroniser
   logic [PIN_COUNT-1:0] in_q;

   pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_q)
   );

   // read response
   logic [REG_W-1:0] rd_mux;

   always_comb begin
      case (sel)
         SEL_DIR_CLR: rd_mux = dir_q;
         SEL_PIN_IN:  rd_mux = in_q;
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_fire;
         if (rd_fire) rsp_rdata <= rd_mux;
      end
   end

   assign pad_out = out_q;
   assign pad_oe  = dir_q;
endmodule

// File: rtl/pin_port_chk.sv
module pin_port_chk #(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [31:0]       req_wdata,
   input logic              rsp_valid,
   input logic [31:0]       rsp_rdata,
   input logic [31:0]       pad_out,
   input logic [31:0]       pad_oe
);
   logic wr, rd;
   logic [31:0] a;
   logic mapped_wr;

   assign wr = req_valid && req_write;
   assign rd = req_valid && !req_write;
   assign a  = 32'(req_addr);
   assign mapped_wr = wr && (a == 32'h00 || a == 32'h04 || a == 32'h08 || a == 32'h0C);

   AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && a == 32'h00) |=> (pad_oe == ($past(pad_oe) | $past(req_wdata)))); // R2

   AST_DIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && a == 32'h04) |=> (pad_oe == ($past(pad_oe) & ~$past(req_wdata)))); // R3

   AST_OUT_LO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && a == 32'h08) |=> (pad_out[15:0] ==
         (($past(pad_out[15:0]) & ~$past(req_wdata[31:16])) |
          ($past(req_wdata[15:0]) & $past(req_wdata[31:16])))
         && $stable(pad_out[31:16]))); // R4

   AST_OUT_HI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && a == 32'h0C) |=> (pad_out[31:16] ==
         (($past(pad_out[31:16]) & ~$past(req_wdata[31:16])) |
          ($past(req_wdata[15:0]) & $past(req_wdata[31:16])))
         && $stable(pad_out[15:0]))); // R5

   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rsp_valid); // R9

   AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rsp_valid); // R9

   AST_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && a != 32'h04 && a != 32'h10) |=> (rsp_rdata == 32'h0)); // R9

   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped_wr |=> ($stable(pad_oe) && $stable(pad_out))); // R10
endmodule

bind pin_port pin_port_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/sim_pin_port.sv
`timescale 1ns/1ps
module sim_pin_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_oe = '0;
   logic [31:0] m_out = '0;

   always #2.5 clk = ~clk;

   pin_port u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] merge16(input logic [15:0] old, input logic [31:0] d);
      return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
   endfunction

   function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
      case (a)
         8'h00: m_oe = m_oe | d;
         8'h04: m_oe = m_oe & ~d;
         8'h08: m_out[15:0]  = merge16(m_out[15:0], d);
         8'h0C: m_out[31:16] = merge16(m_out[31:16], d);
         default: ;
      endcase
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h04:   return m_oe;
         8'h10:   return pad_in;
         default: return 32'h0;
      endcase
   endfunction

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      model_write(a, d);
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 rsp_valid", {31'b0, rsp_valid}, 32'h1);
      d = rsp_rdata;
   endtask

   function automatic logic [7:0] pick_addr(input int unsigned r);
      case (r % 8)
         0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;
         4: return 8'h10;  5: return 8'h14;  6: return 8'h40;  default: return 8'hFC;
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %08h expected %08h", 32'h0, 32'h1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 pad_out", pad_out, 32'h0);
      chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pad_oe after release", pad_oe, 32'h0);

      // R6: preload while input, then enable
      do_write(8'h08, 32'h0008_0008);
      chk("R6 preload pad_out", pad_out, 32'h0000_0008);
      chk("R6 preload pad_oe", pad_oe, 32'h0);
      do_write(8'h00, 32'h0000_0008);
      chk("R6 oe rises", pad_oe, 32'h0000_0008);
      chk("R6 value present", pad_out, 32'h0000_0008);

      // R2/R3 partial masks
      do_write(8'h00, 32'hF000_0001);
      chk("R2 set keeps others", pad_oe, 32'hF000_0009);
      do_write(8'h04, 32'h3000_0008);
      chk("R3 clear keeps others", pad_oe, 32'hC000_0001);
      do_read(8'h04, rd);
      chk("R7 direction readback", rd, 32'hC000_0001);

      // R4/R5 partial enables
      do_write(8'h08, 32'h00F0_FFFF);
      chk("R4 low half masked", pad_out, 32'h0000_00F8);
      do_write(8'h0C, 32'h8001_FFFE);
      chk("R5 high half masked", pad_out, 32'h8000_00F8);
      do_write(8'h0C, 32'h0000_FFFF);
      chk("R5 zero enable no change", pad_out, 32'h8000_00F8);

      // R10 stray writes
      do_write(8'h10, 32'hFFFF_FFFF);
      do_write(8'h14, 32'hFFFF_FFFF);
      do_write(8'h02, 32'hFFFF_FFFF);
      chk("R10 oe unchanged", pad_oe, 32'hC000_0001);
      chk("R10 out unchanged", pad_out, 32'h8000_00F8);

      // R9 zero reads and single-cycle response
      do_read(8'h00, rd); chk("R9 read set reg", rd, 32'h0);
      do_read(8'h08, rd); chk("R9 read out lo", rd, 32'h0);
      do_read(8'h0C, rd); chk("R9 read out hi", rd, 32'h0);
      do_read(8'h20, rd); chk("R9 read unmapped", rd, 32'h0);
      @(negedge clk);
      chk("R9 rsp drops", {31'b0, rsp_valid}, 32'h0);
      do_write(8'h00, 32'h0);
      chk("R9 no rsp after write", {31'b0, rsp_valid}, 32'h0);

      // R8 synchroniser latency: back-to-back reads old, old, new
      pad_in = 32'h1234_5678;
      repeat (3) @(negedge clk);
      @(negedge clk);
      pad_in = 32'hCAFE_0F0F;
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10;
      @(negedge clk);
      chk("R8 edge k old", rsp_rdata, 32'h1234_5678);
      @(negedge clk);
      chk("R8 edge k+1 old", rsp_rdata, 32'h1234_5678);
      @(negedge clk);
      chk("R8 edge k+2 new", rsp_rdata, 32'hCAFE_0F0F);
      req_valid = 1'b0;

      // random mix, pad_in held steady
      pad_in = $urandom;
      repeat (3) @(negedge clk);
      for (int n = 0; n < 400; n++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = pick_addr($urandom);
         d = $urandom;
         if ($urandom % 3 != 0) begin
            do_write(a, d);
            chk("R2 R3 R10 random pad_oe", pad_oe, m_oe);
            chk("R4 R5 R10 random pad_out", pad_out, m_out);
         end else begin
            do_read(a, rd);
            chk("R7 R8 R9 random read", rd, model_read(a));
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule